// File: doc/BRIEF.md
# Shared-Counter Ramp Digitizer Back End

This block is the digital half of a many-channel single-slope (Wilkinson) converter. One shared counter runs while an external ramp sweeps past every channel's comparator. When a channel's comparator switches, that channel's latch freezes the counter value. The frozen value is the channel's digitised amplitude.

The counter moves on both edges of the back-end clock. Here this is modelled as one step per cycle of `clk`, which runs at twice the back-end rate. A counter-reset strobe `cnt_clr` arms a conversion. The counter stops when it reaches a programmable top value. Any channel that has not switched by then is given the top value, and `done` rises.

An optional dynamic-start mode keeps the counter at zero until a programmed number of channels have switched. Channels near the common baseline switch first and read zero, so the common-mode offset of all channels is removed while the conversion runs. The comparator edge that counts as a switch is selectable.

Top module: `wilk_adc_backend`

## Requirements
- R1: After `rst_n` is released, `done` is 1 and every code is 0. Comparator activity before the first `cnt_clr` leaves the codes at 0.
- R2: A cycle with `cnt_clr` high clears every code to 0, clears `done` to 0 and sets the counter to 0.
- R3: With dynamic start off, a channel whose comparator switches just before the k-th `clk` edge after the `cnt_clr` edge (k ≥ 1) gets code k-1, limited to `modulo`.
- R4: With `fall_mode` = 0 only a 0→1 comparator transition captures. With `fall_mode` = 1 only a 1→0 transition captures. A transition in the other direction is ignored.
- R5: A channel captures only its first qualifying transition after `cnt_clr`. Later transitions do not change its code.
- R6: The counter never passes `modulo`. `done` rises on the edge where the counter already held `modulo` (edge `modulo`+1 after `cnt_clr` with immediate start). At that edge every channel not yet captured gets code `modulo`.
- R7: While `done` is 1 and `cnt_clr` is low, `done` and all codes hold, whatever the comparators do.
- R8: With `dyn_en` = 1, the counter stays at 0 until the number of captured channels reaches `dyn_count`. Channels captured while it is held read 0. Counting starts on the next edge.
- R9: `dyn_en` = 0, or `dyn_count` = 0, starts the counter immediately.
- R10: In dynamic mode, if fewer than `dyn_count` channels ever switch, `done` stays 0 and every captured code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; one counter step per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_clr | input | 1 | Counter-reset strobe that arms a conversion |
| cmp_in | input | NCH | Comparator outputs, one per channel |
| modulo | input | CW | Top count value |
| fall_mode | input | 1 | 0: rising comparator edge captures; 1: falling edge captures |
| dyn_en | input | 1 | Enable dynamic (common-mode) start |
| dyn_count | input | NW | Channels that must capture before counting starts |
| codes | output | NCH*CW | Converted values; channel i at bits [i*CW +: CW] |
| done | output | 1 | Conversion finished; high after reset until armed |

## Verification
A comparator change driven before the k-th edge after the clear is seen at that same edge. It shows on `codes` after that edge, holding the counter value from before the edge. `done` appears after edge `modulo`+1, or `modulo`+2 when dynamic start waits for channels that switched at edge 1. The bench drives every input on the falling edge of `clk` and counts edges from the clear. It checks `done` after each edge against that arithmetic. Each channel's code is checked once the run has settled, against min(max(k-offset,0), modulo) worked out from its scheduled edge.

// File: rtl/wilk_adc_pkg.sv
package wilk_adc_pkg;

    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } cmp_pol_e;

endpackage

// File: rtl/wilk_edge_detect.sv
module wilk_edge_detect
    import wilk_adc_pkg::*;
#(
    parameter int NCH = 128
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmp_in,
    input  cmp_pol_e       pol,
    output logic [NCH-1:0] fire
);

    typedef struct packed {
        logic [NCH-1:0] prev;
    } ed_state_t;

    ed_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cmp_in;
        if (pol == POL_FALL) begin
            fire = st_q.prev & ~cmp_in;
        end else begin
            fire = ~st_q.prev & cmp_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wilk_counter.sv
module wilk_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run_ok,
    input  logic [CW-1:0] modulo,
    output logic [CW-1:0] count,
    output logic          done,
    output logic          term
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fin;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        term = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
            st_d.fin = 1'b0;
        end else if (!st_q.fin && run_ok) begin
            if (st_q.cnt == modulo) begin
                st_d.fin = 1'b1;
                term     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.fin <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign done  = st_q.fin;

endmodule

// File: rtl/wilk_latch_bank.sv
module wilk_latch_bank #(
    parameter int NCH = 128,
    parameter int CW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              active,
    input  logic              term,
    input  logic [NCH-1:0]    fire,
    input  logic [CW-1:0]     count,
    output logic [NCH*CW-1:0] codes,
    output logic [NCH-1:0]    cap
);

    typedef struct packed {
        logic [CW-1:0] code;
        logic          held;
    } lat_state_t;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        lat_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (clr) begin
                st_d.code = '0;
                st_d.held = 1'b0;
            end else if (active && !st_q.held && (fire[g] || term)) begin
                st_d.code = count;
                st_d.held = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign codes[g*CW +: CW] = st_q.code;
        assign cap[g]            = st_q.held;
    end

endmodule

// File: rtl/wilk_adc_backend.sv
module wilk_adc_backend
    import wilk_adc_pkg::*;
#(
    parameter int NCH = 128,
    parameter int CW  = 8,
    localparam int NW = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clr,
    input  logic [NCH-1:0]    cmp_in,
    input  logic [CW-1:0]     modulo,
    input  logic              fall_mode,
    input  logic              dyn_en,
    input  logic [NW-1:0]     dyn_count,
    output logic [NCH*CW-1:0] codes,
    output logic              done
);

    logic [NCH-1:0] fire_w;
    logic [NCH-1:0] cap_w;
    logic [CW-1:0]  count_w;
    logic           term_w;
    logic           run_ok_w;
    logic [NW-1:0]  ncap_w;
    cmp_pol_e       pol_w;

    function automatic logic [NW-1:0] tally(input logic [NCH-1:0] v);
        logic [NW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NCH; i++) begin
            acc = acc + NW'(v[i]);
        end
        return acc;
    endfunction

    always_comb begin
        pol_w    = fall_mode ? POL_FALL : POL_RISE;
        ncap_w   = tally(cap_w);
        run_ok_w = !dyn_en || (ncap_w >= dyn_count);
    end

    wilk_edge_detect #(.NCH(NCH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_in (cmp_in),
        .pol    (pol_w),
        .fire   (fire_w)
    );

    wilk_counter #(.CW(CW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .run_ok (run_ok_w),
        .modulo (modulo),
        .count  (count_w),
        .done   (done),
        .term   (term_w)
    );

    wilk_latch_bank #(.NCH(NCH), .CW(CW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .active (!done),
        .term   (term_w),
        .fire   (fire_w),
        .count  (count_w),
        .codes  (codes),
        .cap    (cap_w)
    );

endmodule

// File: rtl/wilk_adc_chk.sv
module wilk_adc_chk #(
    parameter int NCH = 128,
    parameter int CW  = 8,
    parameter int NW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clr,
    input logic              dyn_en,
    input logic [NW-1:0]     dyn_count,
    input logic [CW-1:0]     count_q,
    input logic              done,
    input logic [NCH-1:0]    cap_q,
    input logic [NCH*CW-1:0] codes
);

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (count_q == '0) && !done && (codes == '0));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CW'(1)));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cnt_clr) |=> done && $stable(codes));

    // R6
    done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (&cap_q));

    // R8
    dyn_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dyn_en && ($countones(cap_q) < int'(dyn_count)) && !cnt_clr && !done)
        |=> $stable(count_q));

endmodule

bind wilk_adc_backend wilk_adc_chk #(.NCH(NCH), .CW(CW), .NW(NW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_clr   (cnt_clr),
    .dyn_en    (dyn_en),
    .dyn_count (dyn_count),
    .count_q   (count_w),
    .done      (done),
    .cap_q     (cap_w),
    .codes     (codes)
);

// File: tb/sim_wilk_adc_backend.sv
module sim_wilk_adc_backend;

    localparam int NCH = 128;
    localparam int CW  = 8;
    localparam int NW  = $clog2(NCH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnt_clr = 1'b0;
    logic [NCH-1:0]    cmp_in = '0;
    logic [CW-1:0]     modulo = '0;
    logic              fall_mode = 1'b0;
    logic              dyn_en = 1'b0;
    logic [NW-1:0]     dyn_count = '0;
    logic [NCH*CW-1:0] codes;
    logic              done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    // kind: 0 normal, 1 glitch, 2 wrong direction, 3 never
    int tog  [NCH];
    int kind [NCH];

    always #5 clk = ~clk;

    wilk_adc_backend #(.NCH(NCH), .CW(CW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_clr   (cnt_clr),
        .cmp_in    (cmp_in),
        .modulo    (modulo),
        .fall_mode (fall_mode),
        .dyn_en    (dyn_en),
        .dyn_count (dyn_count),
        .codes     (codes),
        .done      (done)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int code_of(input int ch);
        return int'(codes[ch*CW +: CW]);
    endfunction

    // One conversion. off: edge offset between toggle edge and code (1 immediate, 2 dyn start at edge 1).
    task automatic run(input bit pol, input int md, input bit den, input int dn,
                       input int seed, input int nstart, input bit starve);
        int off;
        int kend;
        int dedge;
        bit inact;
        off   = (den && dn > 0) ? 2 : 1;
        dedge = md + off;
        kend  = 2 * md + 24;
        inact = pol;
        for (int i = 0; i < NCH; i++) begin
            if (i < nstart) begin
                kind[i] = 0; tog[i] = 1;
            end else if (starve) begin
                kind[i] = 3; tog[i] = 0;
            end else begin
                kind[i] = (i % 16 == 5) ? 1 : (i % 16 == 9) ? 2 : (i % 16 == 13) ? 3 : 0;
                tog[i]  = 2 + ((i * 37 + seed) % (md + 8));
            end
        end
        @(negedge clk);
        fall_mode = pol;
        modulo    = CW'(md);
        dyn_en    = den;
        dyn_count = NW'(dn);
        for (int i = 0; i < NCH; i++) cmp_in[i] = (kind[i] == 2) ? ~inact : inact;
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        check("R2", int'(done), 0, "done after clear");
        for (int i = 0; i < NCH; i++) check("R2", code_of(i), 0, "code after clear");
        for (int k = 1; k <= kend; k++) begin
            for (int i = 0; i < NCH; i++) begin
                if (kind[i] == 0 && k == tog[i]) cmp_in[i] = ~inact;
                if (kind[i] == 1) begin
                    if (k == tog[i] || k == tog[i] + 2) cmp_in[i] = ~inact;
                    if (k == tog[i] + 1) cmp_in[i] = inact;
                end
                if (kind[i] == 2 && k == 3) cmp_in[i] = inact;
            end
            @(negedge clk);
            if (starve) check("R10", int'(done), 0, "done while starved");
            else check("R6", int'(done), (k >= dedge) ? 1 : 0, $sformatf("done after edge %0d", k));
        end
        for (int i = 0; i < NCH; i++) begin
            int e;
            if (starve) e = 0;
            else if (kind[i] >= 2) e = md;
            else begin
                e = tog[i] - off;
                if (e < 0) e = 0;
                if (e > md) e = md;
            end
            if (starve) check("R10", code_of(i), e, $sformatf("ch%0d", i));
            else if (kind[i] == 1) check("R5", code_of(i), e, $sformatf("glitch ch%0d", i));
            else if (kind[i] == 2) check("R4", code_of(i), e, $sformatf("wrong-edge ch%0d", i));
            else if (tog[i] >= dedge) check("R7", code_of(i), e, $sformatf("late ch%0d", i));
            else if (den && dn > 0) check("R8", code_of(i), e, $sformatf("dyn ch%0d", i));
            else if (den) check("R9", code_of(i), e, $sformatf("zero-count ch%0d", i));
            else check("R3", code_of(i), e, $sformatf("ch%0d", i));
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(done), 1, "done after reset");
        cmp_in = '1;
        @(negedge clk);
        cmp_in = '0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NCH; i++) check("R1", code_of(i), 0, $sformatf("idle ch%0d", i));
        check("R1", int'(done), 1, "done while idle");

        run(1'b0, 255, 1'b0, 0, 1, 0, 1'b0);   // R3 R4 R5 full range
        run(1'b1, 100, 1'b0, 0, 7, 0, 1'b0);   // R4 falling polarity
        run(1'b0, 0,   1'b0, 0, 3, 0, 1'b0);   // R6 zero modulo
        run(1'b0, 60,  1'b1, 4, 11, 4, 1'b0);  // R8 dynamic start
        run(1'b1, 30,  1'b1, 0, 5, 0, 1'b0);   // R9 zero count
        run(1'b0, 20,  1'b1, 10, 2, 4, 1'b1);  // R10 threshold never met
        run(1'b0, 45,  1'b0, 0, 9, 0, 1'b0);   // R2 clear after starved run

        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule